// File: doc/BRIEF.md
# Three-Operand NaN Selection Unit

This combinational unit sits beside the datapath of a fused multiply-add stage that computes (a*b)+c on single-precision words. When at least one of the three operands is a NaN, it decides which NaN becomes the result, whether the invalid-operation exception fires, and whether the result is replaced by the canonical default NaN. Arithmetic on ordinary operands belongs to the surrounding datapath. That datapath uses `nan_hit` to choose between its own sum and `nan_out`.

The unit has no state. Its three internal steps are fixed: per-operand classification (quiet, signalling, or not a NaN), a source arbiter, and an output stage. The arbiter resolves to one of four picks: `SRC_A`, `SRC_B`, `SRC_C` or `SRC_DFLT`. Two priority policies are available, chosen by a static select. The caller flags a product of zero times infinity, which changes how a NaN addend is treated. A default-NaN mode overrides the data result only after the exception flag has been formed.

Top module: `nan_pick_fma`

## Requirements
- R1: An operand is a quiet NaN when its exponent field (bits 30:23) is all ones and fraction bit 22 is set. It is a signalling NaN when the exponent is all ones, bit 22 is clear and the fraction (bits 22:0) is nonzero. Every other word is not a NaN.
- R2: `nan_hit` is 1 exactly when at least one operand is a NaN. While it is 0, `inv_flag` is 0 and `nan_out` is 0x7FC00000.
- R3: `inv_flag` is 1 whenever any operand is a signalling NaN.
- R4: With `pol_alt`=0, `prod_zero_inf`=1 and c a quiet NaN, `inv_flag` is 1 and `nan_out` is the default NaN 0x7FC00000.
- R5: With `pol_alt`=0, outside the R4 case, the source is chosen in this order from first to last: signalling c, signalling a, signalling b, quiet c, quiet a, then b.
- R6: With `pol_alt`=1 and `prod_zero_inf`=1, `inv_flag` is 1 and the source is c. The caller asserts `prod_zero_inf` only when a and b are not NaNs.
- R7: With `pol_alt`=1 and `prod_zero_inf`=0, the source is a if a is any NaN, else c if c is any NaN, else b.
- R8: With `force_dflt`=1 and `nan_hit`=1, `nan_out` is 0x7FC00000. `inv_flag` keeps the value it would have without the override.
- R9: An operand chosen as the source is output with bit 22 forced to 1. Sign, exponent and the remaining fraction bits are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | 32 | Multiplicand |
| op_b | input | 32 | Multiplier |
| op_c | input | 32 | Addend |
| prod_zero_inf | input | 1 | Product is zero times infinity |
| force_dflt | input | 1 | Default-NaN mode |
| pol_alt | input | 1 | Priority policy: 0 primary, 1 alternate |
| nan_out | output | 32 | Selected, quieted NaN result |
| inv_flag | output | 1 | Invalid-operation exception |
| nan_hit | output | 1 | At least one operand is a NaN |

## Verification
Assertions are evaluated whenever the inputs change. They check four rules: a signalling NaN always raises the exception; the exception stays low when no operand is a NaN; every result with `nan_hit` high is a quiet NaN; and default-NaN mode yields the canonical word. Only the bench's sweep can show the priority orders of both policies, the zero-times-infinity rules and the preservation of payload and sign. The sweep covers every class combination of the three operands under both policies and both modes, and compares each result with a model computed in the bench.

// File: rtl/nanpick_pkg.sv
package nanpick_pkg;
    typedef enum logic [1:0] {
        SRC_A    = 2'd0,
        SRC_B    = 2'd1,
        SRC_C    = 2'd2,
        SRC_DFLT = 2'd3
    } src_e;

    typedef enum logic {
        POL_PRIMARY   = 1'b0,
        POL_ALTERNATE = 1'b1
    } policy_e;

    localparam int N_OPS = 3;
    localparam int IDX_A = 0;
    localparam int IDX_B = 1;
    localparam int IDX_C = 2;
endpackage

// File: rtl/nanpick_classify.sv
module nanpick_classify #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic [EXP_W+FRAC_W:0] word_i,
    output logic                  quiet_o,
    output logic                  signal_o
);
    logic [EXP_W-1:0]  exp_f;
    logic [FRAC_W-1:0] frac_f;
    logic              exp_max;

    always_comb begin
        exp_f    = word_i[FRAC_W +: EXP_W];
        frac_f   = word_i[FRAC_W-1:0];
        exp_max  = &exp_f;
        quiet_o  = exp_max & frac_f[FRAC_W-1];
        signal_o = exp_max & ~frac_f[FRAC_W-1] & (|frac_f);
    end
endmodule

// File: rtl/nanpick_arbiter.sv
module nanpick_arbiter
    import nanpick_pkg::*;
(
    input  logic [N_OPS-1:0] quiet_i,
    input  logic [N_OPS-1:0] signal_i,
    input  logic             zero_inf_i,
    input  policy_e          policy_i,
    output src_e             pick_o,
    output logic             rule_inv_o
);
    logic [N_OPS-1:0] any_nan;

    always_comb begin
        any_nan    = quiet_i | signal_i;
        pick_o     = SRC_B;
        rule_inv_o = 1'b0;
        unique case (policy_i)
            POL_PRIMARY: begin
                if (zero_inf_i && quiet_i[IDX_C]) begin
                    pick_o     = SRC_DFLT;
                    rule_inv_o = 1'b1;
                end else if (signal_i[IDX_C]) pick_o = SRC_C;
                else if (signal_i[IDX_A])     pick_o = SRC_A;
                else if (signal_i[IDX_B])     pick_o = SRC_B;
                else if (quiet_i[IDX_C])      pick_o = SRC_C;
                else if (quiet_i[IDX_A])      pick_o = SRC_A;
                else                          pick_o = SRC_B;
            end
            POL_ALTERNATE: begin
                if (zero_inf_i) begin
                    pick_o     = SRC_C;
                    rule_inv_o = 1'b1;
                end else if (any_nan[IDX_A]) pick_o = SRC_A;
                else if (any_nan[IDX_C])     pick_o = SRC_C;
                else                         pick_o = SRC_B;
            end
        endcase
    end
endmodule

// File: rtl/nan_pick_fma.sv
module nan_pick_fma
    import nanpick_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic [EXP_W+FRAC_W:0] op_a,
    input  logic [EXP_W+FRAC_W:0] op_b,
    input  logic [EXP_W+FRAC_W:0] op_c,
    input  logic                  prod_zero_inf,
    input  logic                  force_dflt,
    input  logic                  pol_alt,
    output logic [EXP_W+FRAC_W:0] nan_out,
    output logic                  inv_flag,
    output logic                  nan_hit
);
    localparam int WORD_W = 1 + EXP_W + FRAC_W;
    localparam int QBIT   = FRAC_W - 1;
    localparam logic [WORD_W-1:0] DFLT_NAN =
        {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};
    localparam logic [WORD_W-1:0] QUIET_MASK = WORD_W'(1) << QBIT;

    logic [WORD_W-1:0] ops [N_OPS];
    logic [N_OPS-1:0]  is_q;
    logic [N_OPS-1:0]  is_s;
    src_e              pick;
    logic              rule_inv;
    policy_e           policy;

    assign ops[IDX_A] = op_a;
    assign ops[IDX_B] = op_b;
    assign ops[IDX_C] = op_c;
    assign policy     = policy_e'(pol_alt);

    for (genvar gi = 0; gi < N_OPS; gi++) begin : g_cls
        nanpick_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
            .word_i  (ops[gi]),
            .quiet_o (is_q[gi]),
            .signal_o(is_s[gi])
        );
    end

    nanpick_arbiter u_arb (
        .quiet_i   (is_q),
        .signal_i  (is_s),
        .zero_inf_i(prod_zero_inf),
        .policy_i  (policy),
        .pick_o    (pick),
        .rule_inv_o(rule_inv)
    );

    always_comb begin
        nan_hit  = |(is_q | is_s);
        inv_flag = nan_hit & ((|is_s) | rule_inv);
        if (!nan_hit || force_dflt || pick == SRC_DFLT) begin
            nan_out = DFLT_NAN;
        end else begin
            nan_out = ops[pick] | QUIET_MASK;
        end
    end

    always_comb begin
        if (|is_s) begin
            p_snan_raises_r3: assert (inv_flag)
                else $error("signalling operand without invalid flag");
        end
        if (!nan_hit) begin
            p_idle_quiet_r2: assert (!inv_flag && nan_out == DFLT_NAN)
                else $error("flag or result active with no NaN operand");
        end
        if (nan_hit) begin
            p_out_is_quiet_r9: assert ((&nan_out[FRAC_W +: EXP_W]) && nan_out[QBIT])
                else $error("result is not a quiet NaN");
        end
        if (nan_hit && force_dflt) begin
            p_dflt_mode_r8: assert (nan_out == DFLT_NAN)
                else $error("default mode did not force canonical NaN");
        end
    end
endmodule

// File: tb/sim_nan_pick_fma.sv
`timescale 1ns/1ps
module sim_nan_pick_fma;
    logic        clk = 1'b0;
    logic [31:0] op_a, op_b, op_c;
    logic        prod_zero_inf, force_dflt, pol_alt;
    logic [31:0] nan_out;
    logic        inv_flag, nan_hit;
    int          checks = 0;
    int          errors = 0;
    logic        done = 1'b0;

    localparam logic [31:0] DNAN = 32'h7FC00000;

    always #2.5 clk = ~clk;

    nan_pick_fma u0 (
        .op_a(op_a), .op_b(op_b), .op_c(op_c),
        .prod_zero_inf(prod_zero_inf), .force_dflt(force_dflt), .pol_alt(pol_alt),
        .nan_out(nan_out), .inv_flag(inv_flag), .nan_hit(nan_hit)
    );

    // operand table: class 0 number, 1 infinity, 2 zero, 3 quiet NaN, 4 signalling NaN
    function automatic logic [31:0] pick_val(int who, int cls);
        logic [31:0] v;
        case (cls)
            0: v = (who == 0) ? 32'h3F800000 : (who == 1) ? 32'h40000000 : 32'h40400000;
            1: v = (who == 1) ? 32'hFF800000 : 32'h7F800000;
            2: v = 32'h00000000;
            3: v = (who == 0) ? 32'hFFC00A0A : (who == 1) ? 32'h7FC00B0B : 32'hFFC00C0C;
            default: v = (who == 0) ? 32'h7F800A01 : (who == 1) ? 32'hFF800B02 : 32'h7F800C03;
        endcase
        return v;
    endfunction

    function automatic bit isq(logic [31:0] w);
        return (w[30:23] == 8'hFF) && w[22];
    endfunction
    function automatic bit iss(logic [31:0] w);
        return (w[30:23] == 8'hFF) && !w[22] && (w[21:0] != 0);
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s a=%h b=%h c=%h z=%0b d=%0b p=%0b actual=%h expected=%h",
                     req, op_a, op_b, op_c, prod_zero_inf, force_dflt, pol_alt, act, exp);
        end
    endtask

    task automatic run_case(logic [31:0] a, logic [31:0] b, logic [31:0] c,
                            bit z, bit d, bit p);
        logic [31:0] src, exp_out;
        bit hit, inv, use_dflt;
        string tag;
        @(posedge clk);
        #1;
        op_a = a; op_b = b; op_c = c;
        prod_zero_inf = z; force_dflt = d; pol_alt = p;
        hit = isq(a) | iss(a) | isq(b) | iss(b) | isq(c) | iss(c);
        inv = iss(a) | iss(b) | iss(c);
        use_dflt = 1'b0;
        src = b;
        if (!p) begin
            tag = "R5";
            if (z && isq(c)) begin use_dflt = 1'b1; inv = 1'b1; tag = "R4"; end
            else if (iss(c)) src = c;
            else if (iss(a)) src = a;
            else if (iss(b)) src = b;
            else if (isq(c)) src = c;
            else if (isq(a)) src = a;
            else src = b;
        end else begin
            tag = "R7";
            if (z) begin src = c; inv = 1'b1; tag = "R6"; end
            else if (isq(a) | iss(a)) src = a;
            else if (isq(c) | iss(c)) src = c;
            else src = b;
        end
        if (!hit) begin inv = 1'b0; tag = "R2"; end
        if (!hit || use_dflt) exp_out = DNAN;
        else if (d) begin exp_out = DNAN; tag = "R8"; end
        else exp_out = src | 32'h00400000; // R9 quieting keeps sign and payload
        @(negedge clk);
        check("R2", {31'b0, nan_hit}, {31'b0, hit});
        check(inv && (iss(a) | iss(b) | iss(c)) ? "R3" : tag, {31'b0, inv_flag}, {31'b0, inv});
        check(tag, nan_out, exp_out);
    endtask

    initial begin
        #100000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        op_a = 0; op_b = 0; op_c = 0;
        prod_zero_inf = 0; force_dflt = 0; pol_alt = 0;
        // R1 idle state: all-zero operands are not NaNs
        @(negedge clk);
        check("R2", {31'b0, nan_hit}, 32'd0);
        check("R2", nan_out, DNAN);
        // R1 boundary: all-ones exponent with zero fraction is infinity, not NaN
        run_case(32'h7F800000, 32'h00000000, 32'hFF800000, 0, 0, 0);
        // R1 boundary: signalling with only the lowest fraction bit
        run_case(32'h00000000, 32'h3F800000, 32'hFF800001, 0, 0, 1);
        // R9 explicit: signalling a keeps negative sign and payload
        run_case(32'hFF812345, 32'h3F800000, 32'h3F800000, 0, 0, 0);
        check("R9", nan_out, 32'hFFC12345);
        // R10-style policy sweep: every class combination, both policies, both modes
        for (int ca = 0; ca < 5; ca++)
            for (int cb = 0; cb < 5; cb++)
                for (int cc = 0; cc < 5; cc++)
                    for (int zi = 0; zi < 2; zi++)
                        for (int di = 0; di < 2; di++)
                            for (int pi = 0; pi < 2; pi++) begin
                                // zero-times-infinity only arises with non-NaN a and b (R6)
                                if (zi == 1 && (ca > 2 || cb > 2)) continue;
                                run_case(pick_val(0, ca), pick_val(1, cb), pick_val(2, cc),
                                         zi[0], di[0], pi[0]);
                            end
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule